// File: doc/BRIEF.md
# Pipelined Burst SRAM Access Controller

This block is the synchronous front end of a small common-I/O cache memory. Every address, strobe, chip-enable, write-control and data input is sampled on the rising clock edge. A state machine decodes each edge as one of these cycle kinds: deselect, begin read, begin write, continue burst or suspend burst. Writes land in an on-chip array organised as byte lanes. Read data passes through an output register, so it reaches the bus one edge after the access. The bus is modelled as a data-out vector plus a separate drive-enable, so the high-Z condition can be observed directly.

Accesses start from either of two address strobes. The processor strobe always starts a read, so a write from that side completes on the following edge. The controller strobe can write on the very edge that carries the address. A 2-bit wraparound burst counter steps through either a linear order or an interleaved (XOR) order. A sleep request drains the block into a low-power state and back out again. Each transition takes two edges, and the array keeps its contents throughout.

States:
- `ST_IDLE`: deselected.
- `ST_READ`: output register may drive.
- `ST_WRITE`: write detected, bus released.
- `ST_NAP_IN`: sleep entry.
- `ST_NAP`: asleep.
- `ST_NAP_OUT`: sleep exit.

Transitions:
- Sleep request high from any awake state goes to `ST_NAP_IN`.
- From `ST_NAP_IN`, a high request moves to `ST_NAP`; a low request moves to `ST_NAP_OUT`.
- `ST_NAP` holds while the request stays high and moves to `ST_NAP_OUT` once it drops.
- `ST_NAP_OUT` goes to `ST_IDLE`, or back to `ST_NAP_IN` if the request rises again.
- In the awake states:
  - A deselect goes to `ST_IDLE`.
  - A begin read goes to `ST_READ`.
  - A begin write goes to `ST_WRITE`.
  - A continue or suspend goes to `ST_WRITE` or `ST_READ`, depending on whether write controls are active.
  - In `ST_IDLE` with no strobe, the block stays put.

Top module: `burst_sram_ctrl`

## Requirements
- R1: The block is selected only when `chip_en_a_n`=0, `chip_en_b`=1 and `chip_en_c_n`=0. A recognised strobe while not selected is a deselect: nothing is written and `rdata_oe` is 0 after that edge.
- R2: `cpu_strobe_n` is ignored while `chip_en_a_n`=1. When both strobes are low on a selected edge, only the processor strobe counts, so nothing is written on that edge.
- R3: A processor-strobe access is a read on its first edge whatever the write controls say. Write controls on the next edge, with no strobe and `advance_n`=1, write the captured address.
- R4: A controller-strobe edge with `cpu_strobe_n`=1 and active write controls writes `wdata` at `addr` on that same edge. `advance_n` has no effect on that edge.
- R5: Write lane mask:
  - `global_wr_n`=0 writes both lanes.
  - Otherwise, with `lane_wr_en_n`=0, lane i is written when `lane_sel_n[i]`=0. Lane 0 is `wdata[8:0]` and lane 1 is `wdata[17:9]`.
  - Lanes not written keep their contents.
- R6: Data read on edge k is on `rdata` after edge k+1. It is driven when the block is in the read state, not blanked, and `out_en_n`=0.
- R7: After a begin read from the deselected state, `rdata_oe` stays 0 until the next edge even with `out_en_n`=0. A begin read that follows a read or a write is not blanked.
- R8: `out_en_n`=1 forces `rdata_oe` to 0 without waiting for a clock. An edge with active write controls leaves `rdata_oe`=0 after it regardless of `out_en_n`.
- R9: With no strobe, `advance_n`=0 and an access in progress, the address steps through the burst and wraps after four steps.
  - Linear order (`burst_linear`=1): the low two bits are (start+n) mod 4.
  - Interleaved order: the low two bits are start XOR n.
  - The upper address bits stay fixed.
- R10: With no strobe and `advance_n`=1 during an access, the current address is reused for a read or, with active write controls, for a write.
- R11: In the deselected state, an edge with no strobe writes nothing, even with active write controls.
- R12: An edge with `sleep_req`=1 performs no access and `rdata_oe` is 0 after it. Once asleep, accesses are ignored until two edges have seen `sleep_req`=0; the third such edge is accepted. Array contents are preserved.
- R13: Synchronous active-high `rst` leaves the block deselected with `rdata_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Access address |
| chip_en_a_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| chip_en_b | input | 1 | Chip enable, active high |
| chip_en_c_n | input | 1 | Chip enable, active low |
| cpu_strobe_n | input | 1 | Processor address strobe, active low |
| ctl_strobe_n | input | 1 | Controller address strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| global_wr_n | input | 1 | Write all lanes, active low |
| lane_wr_en_n | input | 1 | Per-lane write enable, active low |
| lane_sel_n | input | LANES | Per-lane write select, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep_req | input | 1 | Sleep request, active high |
| burst_linear | input | 1 | 1 selects linear burst order, 0 selects interleaved |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Output register contents |
| rdata_oe | output | 1 | Bus drive enable for rdata |

## Verification
The hardest situations to reach from the ports are the two-edge processor write and the strobes that must be ignored. In each, an edge carries strobes or write controls that would corrupt the array if decoded wrongly. The stimulus handles this by first filling every address with a computed pattern. It then applies the suspect edge, puts the block through a deselect, and reads the address back, so a stray write shows up as a pattern mismatch. For a processor strobe ignored under chip enable 1, the output is held in a read of another address across the ignored edge. Sleep exit is probed by presenting a controller write on every edge after the request drops, so the first accepted edge is identified by which addresses changed.

// File: rtl/bsram_pkg.sv
`timescale 1ns/1ps
package bsram_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_READ, ST_WRITE, ST_NAP_IN, ST_NAP, ST_NAP_OUT
    } bsram_state_e;

    typedef enum logic [2:0] {
        AC_NONE, AC_DESEL, AC_BEGIN_RD, AC_BEGIN_WR, AC_CONT, AC_SUSP
    } bsram_acc_e;
endpackage

// File: rtl/bsram_burst_gen.sv
`timescale 1ns/1ps
module bsram_burst_gen #(
    parameter int ADDR_W  = 10,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              adv_i,
    input  logic              linear_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [BURST_W-1:0] STEP = 1;

    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] cnt_q;
    logic [BURST_W-1:0] cnt_sel;
    logic [BURST_W-1:0] low;

    always_comb begin
        cnt_sel = adv_i ? cnt_q + STEP : cnt_q;
        low     = linear_i ? base_q[BURST_W-1:0] + cnt_sel
                           : base_q[BURST_W-1:0] ^ cnt_sel;
        addr_o  = load_i ? addr_i : {base_q[ADDR_W-1:BURST_W], low};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load_i) begin
            base_q <= addr_i;
            cnt_q  <= '0;
        end else if (adv_i) begin
            cnt_q  <= cnt_sel;
        end
    end

    AST_BURST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
        (!load_i) |=> (base_q == $past(base_q))); // R9
endmodule

// File: rtl/bsram_array.sv
`timescale 1ns/1ps
module bsram_array #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        we_i,
    input  logic [ADDR_W-1:0]       waddr_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0]       raddr_i,
    output logic [LANES*LANE_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we_i[g]) mem[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
        end

        assign rdata_o[g*LANE_W +: LANE_W] = mem[raddr_i];
    end
endmodule

// File: rtl/burst_sram_ctrl.sv
`timescale 1ns/1ps
module burst_sram_ctrl
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    chip_en_a_n,
    input  logic                    chip_en_b,
    input  logic                    chip_en_c_n,
    input  logic                    cpu_strobe_n,
    input  logic                    ctl_strobe_n,
    input  logic                    advance_n,
    input  logic                    global_wr_n,
    input  logic                    lane_wr_en_n,
    input  logic [LANES-1:0]        lane_sel_n,
    input  logic                    out_en_n,
    input  logic                    sleep_req,
    input  logic                    burst_linear,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_oe
);
    localparam int DATA_W  = LANES * LANE_W;
    localparam int BURST_W = 2;

    bsram_state_e state_q, state_d;
    bsram_acc_e   acc;

    logic              sel, cpu_hit, any_strobe, awake, wr_any, is_read;
    logic [LANES-1:0]  lanes_w, lane_we;
    logic              gen_load, gen_adv;
    logic [ADDR_W-1:0] addr_use, rd_addr_q;
    logic [DATA_W-1:0] arr_rdata, out_q;
    logic              first_q, rd_pend_q;

    // Cycle decode
    always_comb begin
        sel        = !chip_en_a_n && chip_en_b && !chip_en_c_n;
        cpu_hit    = !cpu_strobe_n && !chip_en_a_n;
        any_strobe = cpu_hit || !ctl_strobe_n;
        lanes_w    = !global_wr_n ? '1 : (!lane_wr_en_n ? ~lane_sel_n : '0);
        wr_any     = |lanes_w;
        awake      = (state_q inside {ST_IDLE, ST_READ, ST_WRITE}) && !sleep_req;

        if (!awake)                  acc = AC_NONE;
        else if (any_strobe && !sel) acc = AC_DESEL;
        else if (cpu_hit)            acc = AC_BEGIN_RD;
        else if (!ctl_strobe_n)      acc = wr_any ? AC_BEGIN_WR : AC_BEGIN_RD;
        else if (state_q == ST_IDLE) acc = AC_NONE;
        else if (!advance_n)         acc = AC_CONT;
        else                         acc = AC_SUSP;

        gen_load = (acc == AC_BEGIN_RD) || (acc == AC_BEGIN_WR);
        gen_adv  = (acc == AC_CONT);
        lane_we  = ((acc == AC_BEGIN_WR) ||
                    (((acc == AC_CONT) || (acc == AC_SUSP)) && wr_any)) ? lanes_w : '0;
        is_read  = (acc == AC_BEGIN_RD) ||
                   (((acc == AC_CONT) || (acc == AC_SUSP)) && !wr_any);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_READ, ST_WRITE: begin
                if (sleep_req) state_d = ST_NAP_IN;
                else begin
                    unique case (acc)
                        AC_DESEL:        state_d = ST_IDLE;
                        AC_BEGIN_RD:     state_d = ST_READ;
                        AC_BEGIN_WR:     state_d = ST_WRITE;
                        AC_CONT, AC_SUSP: state_d = wr_any ? ST_WRITE : ST_READ;
                        default:         state_d = state_q;
                    endcase
                end
            end
            ST_NAP_IN:  state_d = sleep_req ? ST_NAP : ST_NAP_OUT;
            ST_NAP:     state_d = sleep_req ? ST_NAP : ST_NAP_OUT;
            ST_NAP_OUT: state_d = sleep_req ? ST_NAP_IN : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            first_q   <= 1'b0;
            rd_pend_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            first_q   <= (acc == AC_BEGIN_RD) && (state_q == ST_IDLE);
            rd_pend_q <= is_read;
        end
    end

    // Read pipeline and output register
    always_ff @(posedge clk) begin
        if (is_read)   rd_addr_q <= addr_use;
        if (rd_pend_q) out_q     <= arr_rdata;
    end

    always_comb begin
        rdata    = out_q;
        rdata_oe = (state_q == ST_READ) && !first_q && !out_en_n;
    end

    bsram_burst_gen #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_burst (
        .clk(clk), .rst(rst), .load_i(gen_load), .adv_i(gen_adv),
        .linear_i(burst_linear), .addr_i(addr), .addr_o(addr_use)
    );

    bsram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
        .clk(clk), .we_i(lane_we), .waddr_i(addr_use), .wdata_i(wdata),
        .raddr_i(rd_addr_q), .rdata_o(arr_rdata)
    );

    AST_DESEL_HIZ: assert property (@(posedge clk) disable iff (rst)
        (acc == AC_DESEL) |=> !rdata_oe); // R1
    AST_CPU_START_READS: assert property (@(posedge clk) disable iff (rst)
        (awake && cpu_hit && sel) |-> (lane_we == '0)); // R3
    AST_WRITE_HIZ: assert property (@(posedge clk) disable iff (rst)
        (|lane_we) |=> !rdata_oe); // R8
    AST_FIRST_BLANK: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && acc == AC_BEGIN_RD) |=> !rdata_oe); // R7
    AST_NAP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (sleep_req || state_q == ST_NAP_OUT) |-> (lane_we == '0)); // R12
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !any_strobe) |-> (lane_we == '0)); // R11
endmodule

// File: tb/burst_sram_ctrl_tb.sv
`timescale 1ns/1ps
module burst_sram_ctrl_tb;
    localparam int AW = 10;
    localparam int LW = 9;
    localparam int NL = 2;
    localparam int DW = LW * NL;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst, chip_en_a_n, chip_en_b, chip_en_c_n, cpu_strobe_n, ctl_strobe_n;
    logic advance_n, global_wr_n, lane_wr_en_n, out_en_n, sleep_req, burst_linear;
    logic [NL-1:0] lane_sel_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata, rdata;
    logic rdata_oe;

    burst_sram_ctrl #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL)) u_dut (
        .clk(clk), .rst(rst), .addr(addr), .chip_en_a_n(chip_en_a_n),
        .chip_en_b(chip_en_b), .chip_en_c_n(chip_en_c_n),
        .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n),
        .advance_n(advance_n), .global_wr_n(global_wr_n),
        .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n),
        .out_en_n(out_en_n), .sleep_req(sleep_req), .burst_linear(burst_linear),
        .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [DW-1:0] model [DEPTH];

    function automatic logic [DW-1:0] pat(input int a);
        logic [31:0] t;
        t = (a * 1237 + 91) ^ (a << 7);
        return t[DW-1:0];
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic quiet();
        chip_en_a_n = 1'b1; chip_en_b = 1'b1; chip_en_c_n = 1'b0;
        cpu_strobe_n = 1'b1; ctl_strobe_n = 1'b1; advance_n = 1'b1;
        global_wr_n = 1'b1; lane_wr_en_n = 1'b1; lane_sel_n = '1;
    endtask

    task automatic sel_on();
        chip_en_a_n = 1'b0; chip_en_b = 1'b1; chip_en_c_n = 1'b0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // controller-strobe write; the model follows the lane rule of R5
    task automatic cwrite(input int a, input logic [DW-1:0] d, input logic gw,
                          input logic bwe, input logic [NL-1:0] bws, input logic adv);
        logic [NL-1:0] mask;
        sel_on(); cpu_strobe_n = 1'b1; ctl_strobe_n = 1'b0;
        addr = AW'(a); wdata = d; global_wr_n = gw; lane_wr_en_n = bwe;
        lane_sel_n = bws; advance_n = adv;
        step();
        quiet();
        mask = !gw ? '1 : (!bwe ? ~bws : '0);
        for (int i = 0; i < NL; i++)
            if (mask[i]) model[a][i*LW +: LW] = d[i*LW +: LW];
    endtask

    task automatic read_chk(input int a, input string req);
        sel_on(); ctl_strobe_n = 1'b0; cpu_strobe_n = 1'b1; addr = AW'(a);
        step();
        quiet();
        step();
        chk(req, 32'(rdata_oe), 32'd1);
        chk(req, 32'(rdata), 32'(model[a]));
    endtask

    task automatic deselect();
        sel_on(); chip_en_b = 1'b0; ctl_strobe_n = 1'b0;
        step();
        quiet();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; quiet(); out_en_n = 1'b0; sleep_req = 1'b0;
        burst_linear = 1'b0; addr = '0; wdata = '0;
        repeat (3) step();
        rst = 1'b0;
        step();
        chk("R13 reset hiz", 32'(rdata_oe), 32'd0);

        // fill and full read sweep
        for (int a = 0; a < DEPTH; a++) cwrite(a, pat(a), 1'b0, 1'b1, 2'b11, 1'b1);
        deselect();
        for (int a = 0; a < DEPTH; a++) read_chk(a, "R6 read sweep");

        // R5: every combination of the write controls
        for (int k = 0; k < 16; k++) begin
            cwrite(100 + k, ~pat(100 + k), k[3], k[2], k[1:0], 1'b1);
            read_chk(100 + k, "R5 lane mask");
        end

        // R4: advance ignored on controller write
        cwrite(200, 18'h2AAAA, 1'b0, 1'b1, 2'b11, 1'b0);
        read_chk(200, "R4 same-edge write");
        read_chk(201, "R4 neighbour untouched");

        // R1: each enable inactive on its own
        for (int k = 0; k < 3; k++) begin
            sel_on();
            if (k == 0) chip_en_a_n = 1'b1;
            if (k == 1) chip_en_b = 1'b0;
            if (k == 2) chip_en_c_n = 1'b1;
            ctl_strobe_n = 1'b0; global_wr_n = 1'b0; addr = AW'(210 + k); wdata = '0;
            step();
            chk("R1 deselect hiz", 32'(rdata_oe), 32'd0);
            quiet(); step();
            read_chk(210 + k, "R1 no write when deselected");
        end

        // R3: processor start ignores write controls, then two-edge write
        sel_on(); cpu_strobe_n = 1'b0; global_wr_n = 1'b0; addr = 10'd220; wdata = '0;
        step();
        deselect();
        read_chk(220, "R3 start is a read");
        sel_on(); cpu_strobe_n = 1'b0; addr = 10'd221;
        step();
        cpu_strobe_n = 1'b1; global_wr_n = 1'b0; advance_n = 1'b1; wdata = 18'h15555;
        step();
        quiet(); model[221] = 18'h15555;
        read_chk(221, "R3 second-edge write");

        // R2: both strobes, then processor strobe masked by enable 1
        sel_on(); cpu_strobe_n = 1'b0; ctl_strobe_n = 1'b0; global_wr_n = 1'b0;
        addr = 10'd230; wdata = '0;
        step();
        deselect();
        read_chk(230, "R2 processor strobe wins");
        read_chk(231, "R2 setup read");
        chip_en_a_n = 1'b1; cpu_strobe_n = 1'b0; addr = 10'd232; advance_n = 1'b1;
        step();
        quiet(); step();
        chk("R2 masked strobe oe", 32'(rdata_oe), 32'd1);
        chk("R2 masked strobe data", 32'(rdata), 32'(model[231]));

        // R10: suspend read and suspend write
        read_chk(240, "R10 setup");
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R10 suspend read", 32'(rdata), 32'(model[240]));
        end
        lane_wr_en_n = 1'b0; lane_sel_n = 2'b10; wdata = 18'h0_01FF; advance_n = 1'b1;
        step();
        quiet(); model[240][LW-1:0] = 9'h1FF;
        read_chk(240, "R10 suspend write lane0");

        // R9: both burst orders, every start offset, with wrap
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                burst_linear = m[0];
                sel_on(); cpu_strobe_n = 1'b0; addr = AW'(300 + s);
                step();
                quiet(); advance_n = 1'b0;
                for (int n = 1; n <= 5; n++) begin
                    int q;
                    if (n == 5) advance_n = 1'b1;
                    step();
                    q = m ? ((s + n - 1) & 3) : (s ^ ((n - 1) & 3));
                    chk("R9 burst order", 32'(rdata), 32'(model[300 + q]));
                end
                quiet();
                deselect();
            end
        end

        // R7: blank after deselect only
        sel_on(); ctl_strobe_n = 1'b0; addr = 10'd310;
        step();
        chk("R7 first cycle blank", 32'(rdata_oe), 32'd0);
        quiet(); step();
        chk("R7 after blank", 32'(rdata), 32'(model[310]));
        sel_on(); ctl_strobe_n = 1'b0; addr = 10'd311;
        step();
        chk("R7 no blank after read oe", 32'(rdata_oe), 32'd1);
        chk("R7 no blank after read data", 32'(rdata), 32'(model[310]));
        quiet(); step();
        chk("R7 back to back", 32'(rdata), 32'(model[311]));
        cwrite(312, 18'h00ABC, 1'b0, 1'b1, 2'b11, 1'b1);
        sel_on(); ctl_strobe_n = 1'b0; addr = 10'd313;
        step();
        chk("R7 no blank after write", 32'(rdata_oe), 32'd1);
        quiet(); step();

        // R8: async output enable and write-forced high-Z
        out_en_n = 1'b1; #1;
        chk("R8 oe async off", 32'(rdata_oe), 32'd0);
        out_en_n = 1'b0; #1;
        chk("R8 oe async on", 32'(rdata_oe), 32'd1);
        global_wr_n = 1'b0; wdata = 18'h3C3C3; advance_n = 1'b1;
        step();
        chk("R8 write forces hiz", 32'(rdata_oe), 32'd0);
        quiet(); model[313] = 18'h3C3C3;
        read_chk(313, "R8 suspend write data");

        // R11: idle with write controls writes nothing
        cwrite(320, 18'h12345, 1'b0, 1'b1, 2'b11, 1'b1);
        deselect();
        global_wr_n = 1'b0; wdata = '0; advance_n = 1'b0;
        step(); step();
        chk("R11 idle hiz", 32'(rdata_oe), 32'd0);
        quiet();
        read_chk(320, "R11 idle no write");

        // R12: sleep entry and exit
        read_chk(330, "R12 setup");
        sleep_req = 1'b1;
        sel_on(); ctl_strobe_n = 1'b0; global_wr_n = 1'b0; wdata = 18'h0F0F0; addr = 10'd331;
        step();
        chk("R12 sleep hiz", 32'(rdata_oe), 32'd0);
        step(); step();
        sleep_req = 1'b0; addr = 10'd332;
        step();
        addr = 10'd333;
        step();
        addr = 10'd334;
        step();
        quiet(); model[334] = 18'h0F0F0;
        read_chk(331, "R12 ignored asleep");
        read_chk(332, "R12 ignored exit1");
        read_chk(333, "R12 ignored exit2");
        read_chk(334, "R12 accepted after exit");
        read_chk(330, "R12 contents kept");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule